// File: doc/BRIEF.md
# Decimal-Programmed Clock Divider

This block divides its input clock by an integer ratio N between 1 and 3999. It raises a single-cycle output pulse once in every N rising edges of that clock. It sits in the feedback path of a frequency synthesizer. The pulse train goes to the phase comparator, and the loop settles when the divided frequency equals the reference, so the synthesized frequency is N times the reference. With a 1 kHz reference, one unit step of N moves the output by 1 kHz.

The ratio is set as packed decimal (BCD), not as binary. A two-bit thousands digit sits above three four-bit digits for hundreds, tens and units. The thousands digit is often tied to a constant, with the user setting the lower three digits. Inside the block, a chain of decade down-counters holds the remaining count. Each digit borrows from the one above when it passes zero. When the count reaches one, the chain reloads from the program word and the pulse is raised for the following cycle. The program word is read only at that reload, so a ratio can be changed at any time without producing a short or stretched period.

Top module: `bcd_ratio_div`

## Requirements
- R1: `pulse_o` is high for one cycle in every N clock cycles. N is decoded from `ratio_bcd_i` as thousands = bits 13:12, hundreds = bits 11:8, tens = bits 7:4 and units = bits 3:0, each bit active high.
- R2: While `rst_ni` is low, `pulse_o` is low. The first pulse appears in the cycle that follows the first rising edge after reset is released.
- R3: `ratio_bcd_i` is sampled only at the reload edge, which is the edge that starts a pulse cycle. A change made between reloads leaves the period in progress unchanged, and the new ratio governs the period after the next pulse.
- R4: A hundreds, tens or units digit coded above 9 (values 10 to 15) is treated as 9.
- R5: A program word of all zeros divides by 1.
- R6: With N = 1, `pulse_o` stays high on every cycle.
- R7: Periods stay exact across decade boundaries, including the ratios 9, 10, 999, 1000 and 3999.
- R8: Four-digit ratios that use the two-bit thousands digit are honoured exactly. For example, 3516 is coded 11 0101 0001 0110 and 3149 is coded 11 0001 0100 1001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_bcd_i | input | 14 | Division ratio as packed BCD, thousands digit in the top two bits |
| pulse_o | output | 1 | One-cycle pulse per N input cycles |

## Verification
A wrong digit value or a lost borrow inside the chain does not stay hidden. It shows up as a period that is too long or too short at the very next pulse, so each measured interval between pulses tells whether the whole chain stepped correctly. A reload that picks up the wrong word, or picks it up at the wrong time, shows up within two periods of a program change. The bench therefore changes the program right after a pulse and also in the middle of a count, and measures both the period that follows and the one after it.

// File: rtl/bcd_ratio_pkg.sv
package bcd_ratio_pkg;
  localparam int unsigned DEC_W   = 4;
  localparam int unsigned DEC_MAX = 9;

  typedef logic [DEC_W-1:0] dec_digit_t;

  function automatic dec_digit_t clamp_digit(input dec_digit_t d);
    return (d > dec_digit_t'(DEC_MAX)) ? dec_digit_t'(DEC_MAX) : d;
  endfunction
endpackage

// File: rtl/ratio_prog_clean.sv
module ratio_prog_clean
  import bcd_ratio_pkg::*;
#(
  parameter int unsigned LOW_DIGITS = 3,
  parameter int unsigned TOP_W      = 2,
  localparam int unsigned PROG_W    = TOP_W + DEC_W * LOW_DIGITS
) (
  input  logic [PROG_W-1:0] raw_i,
  output logic [PROG_W-1:0] clean_o
);
  logic [PROG_W-1:0] clamped;

  for (genvar g = 0; g < LOW_DIGITS; g++) begin : g_low
    assign clamped[DEC_W*g +: DEC_W] = clamp_digit(raw_i[DEC_W*g +: DEC_W]);
  end
  assign clamped[PROG_W-1 -: TOP_W] = raw_i[PROG_W-1 -: TOP_W];

  // an all-zero program behaves as divide-by-1
  always_comb begin
    clean_o = clamped;
    if (clamped == '0) clean_o = PROG_W'(1);
  end
endmodule

// File: rtl/ratio_digit.sv
module ratio_digit #(
  parameter int unsigned W       = 4,
  parameter int unsigned MAX     = 9,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] digit_o,
  output logic         borrow_o
);
  logic [W-1:0] digit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     digit_q <= W'(RST_VAL);
    else if (load_i) digit_q <= load_val_i;
    else if (dec_i)  digit_q <= (digit_q == '0) ? W'(MAX) : digit_q - W'(1);
  end

  assign digit_o  = digit_q;
  assign borrow_o = dec_i & (digit_q == '0);

  if (MAX < (2**W) - 1) begin : g_bound_chk
    AST_DIGIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      digit_q <= W'(MAX)); // R7
  end
endmodule

// File: rtl/bcd_ratio_div.sv
module bcd_ratio_div
  import bcd_ratio_pkg::*;
#(
  parameter int unsigned LOW_DIGITS = 3,
  parameter int unsigned TOP_W      = 2,
  localparam int unsigned PROG_W    = TOP_W + DEC_W * LOW_DIGITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PROG_W-1:0] ratio_bcd_i,
  output logic              pulse_o
);
  localparam int unsigned NDIG = LOW_DIGITS + 1;

  logic [PROG_W-1:0] prog_clean;
  logic [PROG_W-1:0] cnt_flat;
  logic [NDIG:0]     dec_chain;
  logic              terminal;
  logic              pulse_q;

  ratio_prog_clean #(
    .LOW_DIGITS(LOW_DIGITS),
    .TOP_W     (TOP_W)
  ) i_clean (
    .raw_i  (ratio_bcd_i),
    .clean_o(prog_clean)
  );

  assign terminal     = (cnt_flat == PROG_W'(1));
  assign dec_chain[0] = ~terminal;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    if (g < LOW_DIGITS) begin : g_dec
      ratio_digit #(
        .W      (DEC_W),
        .MAX    (DEC_MAX),
        .RST_VAL((g == 0) ? 1 : 0)
      ) i_digit (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (terminal),
        .load_val_i(prog_clean[DEC_W*g +: DEC_W]),
        .dec_i     (dec_chain[g]),
        .digit_o   (cnt_flat[DEC_W*g +: DEC_W]),
        .borrow_o  (dec_chain[g+1])
      );
    end else begin : g_top
      ratio_digit #(
        .W      (TOP_W),
        .MAX    ((2**TOP_W) - 1),
        .RST_VAL(0)
      ) i_digit (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (terminal),
        .load_val_i(prog_clean[PROG_W-1 -: TOP_W]),
        .dec_i     (dec_chain[g]),
        .digit_o   (cnt_flat[PROG_W-1 -: TOP_W]),
        .borrow_o  (dec_chain[g+1])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= terminal;
  end

  assign pulse_o = pulse_q;

  AST_RELOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (cnt_flat == $past(prog_clean))); // R3
  AST_COUNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_flat != '0); // R5
  AST_UNIT_CONTINUOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && cnt_flat == PROG_W'(1)) |=> pulse_o); // R6

  for (genvar g = 0; g < LOW_DIGITS; g++) begin : g_clean_chk
    AST_CLEAN_DIGIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prog_clean[DEC_W*g +: DEC_W] <= dec_digit_t'(DEC_MAX)); // R4
  end
endmodule

// File: tb/test_bcd_ratio_div.sv
module test_bcd_ratio_div;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] ratio_bcd_i = 14'h0010;
  logic        pulse_o;

  typedef struct { int n; string tag; } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_pulse = 0;
  bit have_last = 0;
  int cur_n = 10;
  string cur_tag = "R1";

  always #4 clk_i = ~clk_i;

  bcd_ratio_div i_bcd_ratio_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ratio_bcd_i(ratio_bcd_i),
    .pulse_o    (pulse_o)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // monitor: measure pulse spacing and score against the queue
  always @(negedge clk_i) begin
    if (rst_ni) begin
      cyc++;
      if (pulse_o) begin
        if (have_last && exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          checks++;
          if (cyc - last_pulse != e.n) begin
            errors++;
            $display("FAIL %s: interval %0d expected %0d", e.tag, cyc - last_pulse, e.n);
          end
        end
        last_pulse = cyc;
        have_last = 1;
      end
    end
  end

  task automatic wait_pulse();
    do begin
      @(negedge clk_i);
      #1;
    end while (!pulse_o);
  endtask

  // driver: change program after a pulse (optionally mid-count) and queue expectations
  task automatic run(input int delay, input logic [13:0] prog, input int n,
                     input int reps, input string tag);
    wait_pulse();
    repeat (delay) @(negedge clk_i);
    #1;
    ratio_bcd_i = prog;
    exp_q.push_back('{cur_n, (delay > 0) ? "R3" : cur_tag});
    for (int k = 0; k < reps; k++) exp_q.push_back('{n, tag});
    cur_n = n;
    cur_tag = tag;
    while (exp_q.size() != 0) begin
      @(negedge clk_i);
      #1;
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pulse_o %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_bit(pulse_o, 1'b0, "R2");
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    check_bit(pulse_o, 1'b1, "R2");
    run(0, 14'h0001, 1, 4, "R6");
    run(0, 14'h0009, 9, 3, "R7");
    run(0, 14'h0010, 10, 3, "R7");
    run(0, 14'h0999, 999, 2, "R7");
    run(0, 14'h1000, 1000, 2, "R7");
    run(400, 14'h0025, 25, 3, "R1");
    run(0, 14'h3999, 3999, 2, "R7");
    run(0, 14'h3516, 3516, 1, "R8");
    run(0, 14'h3149, 3149, 1, "R8");
    run(0, 14'h0000, 1, 3, "R5");
    run(0, 14'h01F2, 192, 2, "R4");
    run(0, 14'h0AFA, 999, 1, "R4");
    run(7, 14'h0037, 37, 2, "R1");
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL R1: watchdog expired, queue %0d expected 0", exp_q.size());
    summary();
    $finish;
  end
endmodule